// File: doc/BRIEF.md
# Pause Loop Exit Detector

This block watches the spin-wait pause events that a guest processor reports and decides when the supervisor should take control. It can trap every pause. It can also trap only pauses that belong to a long spin loop. A free-running tick counter timestamps every event. Two registers hold the start time of the current burst of pauses and the time of the most recent pause in it.

A burst continues for as long as consecutive pauses stay close together. Two programmable values set the limits. The gap value is the largest allowed spacing between pauses before a new burst begins. The window value is how long a burst may last before it counts as a spin loop. Loop tracking runs only at the most privileged level. An exit request leaves the block as a single-cycle pulse with a reason code.

Top module: `pause_loop_detector`

## Requirements
- R1: When `pause_exit_en_i` is 1, every pause strobe causes an exit with reason code 2'd1 (unconditional), at any privilege level.
- R2: A pause qualifies for loop tracking only when `loop_exit_en_i` is 1 and `priv_lvl_i` is 0. A pause that does not qualify raises no loop exit and leaves the burst registers unchanged.
- R3: If the ticks elapsed since the last qualifying pause are strictly greater than `gap_i`, the current tick becomes the burst start and no loop exit is raised. An elapsed time equal to the gap keeps the burst going.
- R4: Otherwise, if the ticks elapsed since the burst start are strictly greater than `window_i`, an exit with reason code 2'd2 (loop) is raised. An elapsed time equal to the window raises nothing.
- R5: Every qualifying pause stores the current tick as the last-pause time, whether or not an exit is raised.
- R6: The tick counter advances by one every cycle. Elapsed times are taken modulo 2^TIME_W, so bursts that span a counter wrap are timed correctly.
- R7: Reset clears the tick counter and both burst registers to zero and drives `exit_o` to 0 and `exit_reason_o` to 2'd0.
- R8: When the unconditional and loop conditions hold on the same pause, exactly one pulse is issued, with reason code 2'd1.
- R9: `exit_o` is high for exactly the one cycle after the strobe that caused it. When `exit_o` is 0, `exit_reason_o` is 2'd0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pause_i | input | 1 | One-cycle strobe per pause event |
| priv_lvl_i | input | PRIV_W | Current privilege level (0 = most privileged) |
| pause_exit_en_i | input | 1 | Exit on every pause |
| loop_exit_en_i | input | 1 | Enable spin-loop detection |
| gap_i | input | TIME_W | Largest spacing between pauses that keeps a burst going |
| window_i | input | TIME_W | Largest burst duration that is tolerated |
| exit_o | output | 1 | Exit request pulse |
| exit_reason_o | output | 2 | 0 none, 1 unconditional, 2 loop |

## Verification
The main stream of pauses uses spacings that fall just under, exactly on, and just over the gap. This separates a burst restart from a continuing burst, and it confirms that the gap comparison is strict. Burst lengths are run exactly at and just past the window so that the strictness of the window comparison is visible on the exit pulse. A pause at a nonzero privilege level, and one with detection disabled, are sent while the window is zero, so any wrongful loop detection would show up as an exit. A reduced-width instance times a burst across a counter wrap, and a check after a mid-run reset shows that the burst registers start from zero.

// File: rtl/pld_pkg.sv
package pld_pkg;
  typedef enum logic [1:0] {
    RSN_NONE  = 2'd0,
    RSN_PAUSE = 2'd1,
    RSN_LOOP  = 2'd2
  } exit_rsn_e;
endpackage

// File: rtl/pld_tick_counter.sv
module pld_tick_counter #(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [TIME_W-1:0] now_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) now_o <= '0;
    else         now_o <= now_o + 1'b1;
  end

  p_count_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> now_o == $past(now_o) + 1'b1);
endmodule

// File: rtl/pld_burst_tracker.sv
module pld_burst_tracker #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned PRIV_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pause_i,
  input  logic [PRIV_W-1:0] priv_lvl_i,
  input  logic              loop_en_i,
  input  logic [TIME_W-1:0] now_i,
  input  logic [TIME_W-1:0] gap_i,
  input  logic [TIME_W-1:0] window_i,
  output logic              loop_hit_o
);
  logic [TIME_W-1:0] first_q, last_q;
  logic [TIME_W-1:0] since_last, since_first;
  logic              qual, gap_hit;

  assign qual        = pause_i && loop_en_i && (priv_lvl_i == '0);
  // modulo subtraction keeps the spacing right across a counter wrap
  assign since_last  = now_i - last_q;
  assign since_first = now_i - first_q;
  assign gap_hit     = since_last > gap_i;
  assign loop_hit_o  = qual && !gap_hit && (since_first > window_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= '0;
      last_q  <= '0;
    end else if (qual) begin
      last_q <= now_i;
      if (gap_hit) first_q <= now_i;
    end
  end

  p_last_tracks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual |=> last_q == $past(now_i));
  p_gap_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qual && gap_hit) |=> first_q == $past(now_i));
  p_unqual_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qual |=> $stable(last_q) && $stable(first_q));
endmodule

// File: rtl/pld_exit_gen.sv
module pld_exit_gen
  import pld_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pause_i,
  input  logic      pause_en_i,
  input  logic      loop_hit_i,
  output logic      exit_o,
  output exit_rsn_e reason_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exit_o   <= 1'b0;
      reason_o <= RSN_NONE;
    end else begin
      exit_o <= pause_i && (pause_en_i || loop_hit_i);
      // unconditional trap wins when both fire
      if (pause_i && pause_en_i)  reason_o <= RSN_PAUSE;
      else if (loop_hit_i)        reason_o <= RSN_LOOP;
      else                        reason_o <= RSN_NONE;
    end
  end

  p_follows_pause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_o |-> $past(pause_i));
  p_single_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_i && pause_en_i && loop_hit_i) |=> exit_o && reason_o == RSN_PAUSE);
endmodule

// File: rtl/pause_loop_detector.sv
module pause_loop_detector
  import pld_pkg::*;
#(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned PRIV_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pause_i,
  input  logic [PRIV_W-1:0] priv_lvl_i,
  input  logic              pause_exit_en_i,
  input  logic              loop_exit_en_i,
  input  logic [TIME_W-1:0] gap_i,
  input  logic [TIME_W-1:0] window_i,
  output logic              exit_o,
  output logic [1:0]        exit_reason_o
);
  logic [TIME_W-1:0] now;
  logic              loop_hit;
  exit_rsn_e         reason;

  pld_tick_counter #(.TIME_W(TIME_W)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .now_o (now)
  );

  pld_burst_tracker #(.TIME_W(TIME_W), .PRIV_W(PRIV_W)) i_burst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pause_i   (pause_i),
    .priv_lvl_i(priv_lvl_i),
    .loop_en_i (loop_exit_en_i),
    .now_i     (now),
    .gap_i     (gap_i),
    .window_i  (window_i),
    .loop_hit_o(loop_hit)
  );

  pld_exit_gen i_exit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pause_i   (pause_i),
    .pause_en_i(pause_exit_en_i),
    .loop_hit_i(loop_hit),
    .exit_o    (exit_o),
    .reason_o  (reason)
  );

  assign exit_reason_o = reason;

  p_uncond_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_i && pause_exit_en_i) |=> exit_o && exit_reason_o == 2'd1);
  p_priv_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_i && !pause_exit_en_i && priv_lvl_i != '0) |=> !exit_o);
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pause_i |=> !exit_o && exit_reason_o == 2'd0);
endmodule

// File: tb/test_pause_loop_detector.sv
`timescale 1ns/1ps
module test_pause_loop_detector;
  typedef struct packed {
    logic [7:0] idle;
    logic [1:0] priv;
    logic       uen;
    logic       len;
    logic [7:0] gap;
    logic [7:0] win;
    logic       exp;
    logic [1:0] rsn;
  } vec_t;

  // idle cycles before the strobe, then config and expected result
  localparam vec_t VEC [14] = '{
    '{8'd10, 2'd0, 1'b0, 1'b1, 8'd4, 8'd10, 1'b0, 2'd0}, // new burst R3
    '{8'd2,  2'd0, 1'b0, 1'b1, 8'd4, 8'd10, 1'b0, 2'd0}, // spacing 3, R5
    '{8'd3,  2'd0, 1'b0, 1'b1, 8'd4, 8'd10, 1'b0, 2'd0}, // spacing == gap R3
    '{8'd3,  2'd0, 1'b0, 1'b1, 8'd4, 8'd10, 1'b1, 2'd2}, // 11 > window R4
    '{8'd0,  2'd0, 1'b0, 1'b1, 8'd4, 8'd10, 1'b1, 2'd2}, // back to back R4
    '{8'd4,  2'd0, 1'b0, 1'b1, 8'd4, 8'd10, 1'b0, 2'd0}, // spacing 5 restart R3
    '{8'd1,  2'd0, 1'b0, 1'b1, 8'd4, 8'd10, 1'b0, 2'd0},
    '{8'd0,  2'd3, 1'b0, 1'b1, 8'd4, 8'd0,  1'b0, 2'd0}, // priv 3 gated R2
    '{8'd0,  2'd0, 1'b0, 1'b1, 8'd4, 8'd0,  1'b1, 2'd2}, // R4
    '{8'd0,  2'd0, 1'b0, 1'b0, 8'd4, 8'd0,  1'b0, 2'd0}, // detection off R2
    '{8'd0,  2'd3, 1'b1, 1'b0, 8'd4, 8'd0,  1'b1, 2'd1}, // R1
    '{8'd0,  2'd0, 1'b1, 1'b1, 8'd4, 8'd0,  1'b1, 2'd1}, // both fire R8
    '{8'd10, 2'd0, 1'b1, 1'b1, 8'd4, 8'd0,  1'b1, 2'd1}, // R1 on restart
    '{8'd0,  2'd0, 1'b0, 1'b1, 8'd4, 8'd0,  1'b1, 2'd2}  // R4
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pause_m = 1'b0, pause_w = 1'b0;
  logic [1:0]  priv = '0;
  logic        uen = 1'b0, len = 1'b0;
  logic [63:0] gap = '0, win = '0;
  logic        exit_m, exit_w;
  logic [1:0]  rsn_m, rsn_w;
  int unsigned cyc = 0;
  int          errors = 0, checks = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  pause_loop_detector i_pause_loop_detector (
    .clk_i(clk), .rst_ni(rst_n), .pause_i(pause_m), .priv_lvl_i(priv),
    .pause_exit_en_i(uen), .loop_exit_en_i(len), .gap_i(gap), .window_i(win),
    .exit_o(exit_m), .exit_reason_o(rsn_m)
  );

  pause_loop_detector #(.TIME_W(8)) i_wrap (
    .clk_i(clk), .rst_ni(rst_n), .pause_i(pause_w), .priv_lvl_i(priv),
    .pause_exit_en_i(uen), .loop_exit_en_i(len), .gap_i(gap[7:0]), .window_i(win[7:0]),
    .exit_o(exit_w), .exit_reason_o(rsn_w)
  );

  task automatic chk(input string req, input logic ae, input logic [1:0] ar,
                     input logic ee, input logic [1:0] er);
    checks++;
    if (ae !== ee || ar !== er) begin
      errors++;
      $display("FAIL %s: exit=%0b reason=%0d expected exit=%0b reason=%0d", req, ae, ar, ee, er);
    end
  endtask

  task automatic wrap_event(input int unsigned at, input logic ee, input logic [1:0] er);
    while (cyc != at) @(negedge clk);
    pause_w = 1'b1;
    @(posedge clk); #1;
    chk($sformatf("R6 wrap event at tick %0d", at), exit_w, rsn_w, ee, er);
    @(negedge clk); pause_w = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 outputs in reset", exit_m, rsn_m, 1'b0, 2'd0);
    rst_n = 1'b1;

    // R6: 8-bit instance, burst from tick 250 across the wrap
    len = 1'b1; gap = 64'd20; win = 64'd8;
    wrap_event(250, 1'b0, 2'd0);
    wrap_event(254, 1'b0, 2'd0);
    wrap_event(258, 1'b0, 2'd0); // elapsed == window, no exit
    wrap_event(262, 1'b1, 2'd2);

    for (int i = 0; i < 14; i++) begin
      for (int k = 0; k < int'(VEC[i].idle); k++) begin
        @(negedge clk); pause_m = 1'b0;
        @(posedge clk); #1;
        if (k == 0) chk($sformatf("R9 pulse ends, row %0d", i), exit_m, rsn_m, 1'b0, 2'd0);
      end
      @(negedge clk);
      priv = VEC[i].priv; uen = VEC[i].uen; len = VEC[i].len;
      gap = 64'(VEC[i].gap); win = 64'(VEC[i].win);
      pause_m = 1'b1;
      @(posedge clk); #1;
      chk($sformatf("R1/R2/R3/R4/R5/R8 row %0d", i), exit_m, rsn_m, VEC[i].exp, VEC[i].rsn);
    end
    @(negedge clk); pause_m = 1'b0;
    @(posedge clk); #1;
    chk("R9 single cycle after last row", exit_m, rsn_m, 1'b0, 2'd0);

    // R7: mid-run reset clears burst registers
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R7 outputs on reset assertion", exit_m, rsn_m, 1'b0, 2'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    uen = 1'b0; len = 1'b1; priv = '0; gap = 64'd100; win = 64'd5;
    while (cyc != 20) @(negedge clk);
    pause_m = 1'b1;
    @(posedge clk); #1;
    chk("R7 burst registers zero after reset", exit_m, rsn_m, 1'b1, 2'd2);
    @(negedge clk); pause_m = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule